// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in the receive byte stream of a network interface and decides for each incoming frame whether the frame is kept. The first six bytes of a frame carry the 48-bit destination address. The block shifts them in and compares the address against three sources: the all-ones broadcast address, which is always accepted; one programmable station (unicast) address; and a table of multicast addresses in which each entry has its own valid bit. A one-cycle decision pulse with an accept flag appears on the cycle after the sixth byte.

Bytes after the address are forwarded one cycle later on the output stream when the frame was accepted. When the frame was dropped they are swallowed up to and including the end-of-frame marker. The address bytes themselves are never forwarded. The station address and the table entries are written through a small configuration port. A snapshot of them is taken when a frame starts, so a write made while a frame is arriving applies from the next frame.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, out_valid and dec_valid are low, every multicast entry is invalid and the station address is zero, so a frame to address zero is accepted and a frame to any other non-broadcast address is dropped.
- R2: A frame whose destination equals the station address is accepted (dec_accept high).
- R3: A frame whose destination is all ones (FF:FF:FF:FF:FF:FF) is accepted even when the multicast table holds no valid entry.
- R4: A frame whose destination equals the address of a multicast entry whose valid bit is set is accepted; an entry written with its valid bit clear does not match.
- R5: A frame whose destination matches none of the station, broadcast or valid multicast addresses is dropped (dec_accept low), including an address that differs from broadcast in one bit.
- R6: The first byte of a frame is the most significant byte of the destination address. dec_valid pulses for exactly one cycle, on the cycle after the sixth valid byte, once per frame.
- R7: For an accepted frame, every byte after the sixth is presented on out_data with out_valid one cycle after it is accepted on the input, in order, and out_last marks the final byte. The six address bytes are never output.
- R8: For a dropped frame, out_valid stays low through the end-of-frame byte, and the next frame is filtered normally.
- R9: A write to the station address or a table entry that occurs after the first byte of a frame has been taken, or in the same cycle as that first byte, does not affect that frame and does apply to the next frame.
- R10: A frame that ends before its sixth byte produces no decision and no output, and the following frame starts address capture afresh.
- R11: Idle cycles (in_valid low) inside a frame, in the address or in the payload, do not change the decision or the forwarded bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid this cycle |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the last of its frame |
| uc_we | input | 1 | Write cfg_addr as the station address |
| mc_we | input | 1 | Write multicast entry cfg_idx |
| cfg_idx | input | IDX_W | Multicast entry index |
| cfg_addr | input | 48 | Address to write |
| cfg_valid | input | 1 | Valid bit written with a multicast entry |
| out_valid | output | 1 | Forwarded byte is valid |
| out_data | output | 8 | Forwarded byte |
| out_last | output | 1 | Forwarded byte ends the frame |
| dec_valid | output | 1 | Decision pulse for the current frame |
| dec_accept | output | 1 | Decision result, held until the next decision |

## Verification
The hardest situation to reach from the ports is a configuration write that lands inside a frame, because the frame's outcome must follow the configuration in force at its first byte. The bench's frame task can raise a station or table write on a chosen byte index of the frame it is sending, including index zero. It then sends the same destination again and expects the opposite decision. Short frames, idle gaps inside the address and the payload, and a byte-reversed station address probe the capture counter and the byte order.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int ADDR_W   = 48;
    localparam int BYTE_W   = 8;
    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int CNT_W    = $clog2(ADDR_BYTES);

    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_PASS = 2'd1,
        ST_DROP = 2'd2
    } rxf_state_e;

    typedef struct packed {
        rxf_state_e          state;
        logic [CNT_W-1:0]    cnt;
        logic [ADDR_W-1:0]   addr;
        logic                dec_v;
        logic                dec_acc;
        logic                out_v;
        logic [BYTE_W-1:0]   out_d;
        logic                out_last;
    } rxf_regs_t;
endpackage

// File: rtl/rxf_addr_table.sv
module rxf_addr_table
    import rxf_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            hold,
    input  logic                            uc_we,
    input  logic                            mc_we,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic                            wr_valid,
    output logic [ADDR_W-1:0]               act_uc,
    output logic [ENTRIES-1:0][ADDR_W-1:0]  act_mc,
    output logic [ENTRIES-1:0]              act_vld
);
    logic [ADDR_W-1:0]              sh_uc_d,  sh_uc_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] sh_mc_d,  sh_mc_q;
    logic [ENTRIES-1:0]             sh_vld_d, sh_vld_q;
    logic [ADDR_W-1:0]              ac_uc_d,  ac_uc_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] ac_mc_d,  ac_mc_q;
    logic [ENTRIES-1:0]             ac_vld_d, ac_vld_q;

    always_comb begin
        sh_uc_d  = sh_uc_q;
        sh_mc_d  = sh_mc_q;
        sh_vld_d = sh_vld_q;
        if (uc_we) begin
            sh_uc_d = wr_addr;
        end
        for (int e = 0; e < ENTRIES; e++) begin
            if (mc_we && (int'(wr_idx) == e)) begin
                sh_mc_d[e]  = wr_addr;
                sh_vld_d[e] = wr_valid;
            end
        end
        ac_uc_d  = ac_uc_q;
        ac_mc_d  = ac_mc_q;
        ac_vld_d = ac_vld_q;
        if (!hold) begin
            ac_uc_d  = sh_uc_q;
            ac_mc_d  = sh_mc_q;
            ac_vld_d = sh_vld_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_uc_q  <= '0;
            sh_mc_q  <= '0;
            sh_vld_q <= '0;
            ac_uc_q  <= '0;
            ac_mc_q  <= '0;
            ac_vld_q <= '0;
        end else begin
            sh_uc_q  <= sh_uc_d;
            sh_mc_q  <= sh_mc_d;
            sh_vld_q <= sh_vld_d;
            ac_uc_q  <= ac_uc_d;
            ac_mc_q  <= ac_mc_d;
            ac_vld_q <= ac_vld_d;
        end
    end

    assign act_uc  = ac_uc_q;
    assign act_mc  = ac_mc_q;
    assign act_vld = ac_vld_q;

    // R9: the snapshot used for comparison is frozen while a frame is in progress
    p_snapshot_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(ac_uc_q) && $stable(ac_mc_q) && $stable(ac_vld_q)));
endmodule

// File: rtl/rxf_match.sv
module rxf_match
    import rxf_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic [ADDR_W-1:0]               dest,
    input  logic [ADDR_W-1:0]               uc,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]  mc,
    input  logic [ENTRIES-1:0]              mc_vld,
    output logic                            accept
);
    logic [ENTRIES-1:0] mc_hit;
    logic               uc_hit;
    logic               bc_hit;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        assign mc_hit[e] = mc_vld[e] && (mc[e] == dest);
    end

    assign uc_hit = (dest == uc);
    assign bc_hit = &dest;
    assign accept = uc_hit || bc_hit || (|mc_hit);
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rxf_pkg::*;
#(
    parameter int MC_ENTRIES = 8,
    parameter int IDX_W      = (MC_ENTRIES > 1) ? $clog2(MC_ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    input  logic               in_last,
    input  logic               uc_we,
    input  logic               mc_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [47:0]        cfg_addr,
    input  logic               cfg_valid,
    output logic               out_valid,
    output logic [7:0]         out_data,
    output logic               out_last,
    output logic               dec_valid,
    output logic               dec_accept
);
    localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(ADDR_BYTES - 1);

    rxf_regs_t r_d, r_q;

    logic [ADDR_W-1:0]                 cand;
    logic                              hold;
    logic                              accept;
    logic [ADDR_W-1:0]                 act_uc;
    logic [MC_ENTRIES-1:0][ADDR_W-1:0] act_mc;
    logic [MC_ENTRIES-1:0]             act_vld;

    assign hold = !((r_q.state == ST_HDR) && (r_q.cnt == '0));
    assign cand = {r_q.addr[ADDR_W-BYTE_W-1:0], in_data};

    rxf_addr_table #(.ENTRIES(MC_ENTRIES), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .uc_we    (uc_we),
        .mc_we    (mc_we),
        .wr_idx   (cfg_idx),
        .wr_addr  (cfg_addr),
        .wr_valid (cfg_valid),
        .act_uc   (act_uc),
        .act_mc   (act_mc),
        .act_vld  (act_vld)
    );

    rxf_match #(.ENTRIES(MC_ENTRIES)) u_match (
        .dest   (cand),
        .uc     (act_uc),
        .mc     (act_mc),
        .mc_vld (act_vld),
        .accept (accept)
    );

    always_comb begin
        r_d          = r_q;
        r_d.dec_v    = 1'b0;
        r_d.out_v    = 1'b0;
        r_d.out_last = 1'b0;
        if (in_valid) begin
            unique case (r_q.state)
                ST_HDR: begin
                    r_d.addr = cand;
                    if (r_q.cnt == LAST_HDR) begin
                        r_d.cnt     = '0;
                        r_d.dec_v   = 1'b1;
                        r_d.dec_acc = accept;
                        if (in_last) begin
                            r_d.state = ST_HDR;
                        end else begin
                            r_d.state = accept ? ST_PASS : ST_DROP;
                        end
                    end else if (in_last) begin
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_PASS: begin
                    r_d.out_v    = 1'b1;
                    r_d.out_d    = in_data;
                    r_d.out_last = in_last;
                    if (in_last) r_d.state = ST_HDR;
                end
                ST_DROP: begin
                    if (in_last) r_d.state = ST_HDR;
                end
                default: r_d.state = ST_HDR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_HDR;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid  = r_q.out_v;
    assign out_data   = r_q.out_d;
    assign out_last   = r_q.out_last;
    assign dec_valid  = r_q.dec_v;
    assign dec_accept = r_q.dec_acc;

    // R6: a decision needs six fresh bytes, so pulses never touch
    p_dec_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);
    // R3: broadcast address always produces an accept
    p_bcast_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (&r_q.addr)) |-> dec_accept);
    // R2: station address match produces an accept
    p_station_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (r_q.addr == act_uc)) |-> dec_accept);
    // R7: forwarded bytes only follow an accepting decision
    p_fwd_needs_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> dec_accept);
    // R7: no address byte leaves on the decision cycle
    p_no_hdr_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> !out_valid);
    // R8: a dropping frame emits nothing
    p_drop_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DROP) |=> !out_valid);
    // R8 / R10: end of frame returns to fresh capture
    p_eof_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> ((r_q.state == ST_HDR) && (r_q.cnt == '0)));
endmodule

// File: tb/rx_dest_filter_tb.sv
`timescale 1ns/1ps
module rx_dest_filter_tb;
    localparam int ENT = 8;
    localparam int IW  = 3;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] STA   = 48'h0211_2233_4455;
    localparam logic [47:0] MCA   = 48'h0100_5E00_0007;
    localparam logic [47:0] MCB   = 48'h3333_0000_00FB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = '0;
    logic uc_we = 1'b0, mc_we = 1'b0, cfg_valid = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [47:0] cfg_addr = '0;
    logic out_valid, out_last, dec_valid, dec_accept;
    logic [7:0] out_data;

    int checks = 0, errors = 0;
    int fwd_cnt = 0, fwd_bad = 0, last_cnt = 0, dec_cnt = 0;
    bit done = 1'b0;

    // frame-embedded write request
    bit pw_uc = 1'b0, pw_mc = 1'b0, pw_vld = 1'b0;
    logic [IW-1:0] pw_idx = '0;
    logic [47:0] pw_addr = '0;

    always #2.5 clk = ~clk;

    rx_dest_filter #(.MC_ENTRIES(ENT), .IDX_W(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .uc_we(uc_we), .mc_we(mc_we), .cfg_idx(cfg_idx),
        .cfg_addr(cfg_addr), .cfg_valid(cfg_valid), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .dec_valid(dec_valid),
        .dec_accept(dec_accept));

    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (out_valid) begin
                if (out_data != 8'(8'hA0 + fwd_cnt)) fwd_bad++;
                fwd_cnt++;
                if (out_last) last_cnt++;
            end
            if (dec_valid) dec_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0; in_last = 1'b0; uc_we = 1'b0; mc_we = 1'b0;
        end
    endtask

    task automatic write_mc(input int idx, input logic [47:0] a, input bit v);
        @(negedge clk);
        mc_we = 1'b1; cfg_idx = IW'(idx); cfg_addr = a; cfg_valid = v;
        @(negedge clk);
        mc_we = 1'b0;
    endtask

    task automatic write_uc(input logic [47:0] a);
        @(negedge clk);
        uc_we = 1'b1; cfg_addr = a;
        @(negedge clk);
        uc_we = 1'b0;
    endtask

    task automatic clr_mon();
        fwd_cnt = 0; fwd_bad = 0; last_cnt = 0; dec_cnt = 0;
    endtask

    // send a frame: six address bytes, npay payload bytes A0,A1,...
    task automatic send_frame(input logic [47:0] da, input int npay, input int gap_at,
                              input int wr_at, input bit exp_acc, input string req);
        int total;
        total = 6 + npay;
        clr_mon();
        for (int i = 0; i < total; i++) begin
            if (i == gap_at) idle(3);
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = (i < 6) ? da[47 - 8*i -: 8] : 8'(8'hA0 + (i - 6));
            in_last  = (i == total - 1);
            uc_we = 1'b0; mc_we = 1'b0;
            if (i == wr_at) begin
                uc_we = pw_uc; mc_we = pw_mc; cfg_idx = pw_idx;
                cfg_addr = pw_addr; cfg_valid = pw_vld;
            end
            if (i == 5) begin
                @(posedge clk); #1;
                check(dec_valid == 1'b1, {req, " R6 decision timing"}, dec_valid, 1);
                check(dec_accept == exp_acc, {req, " decision"}, dec_accept, exp_acc);
            end
        end
        idle(4);
        check(dec_cnt == 1, {req, " R6 one pulse"}, dec_cnt, 1);
        check(fwd_cnt == (exp_acc ? npay : 0), {req, " R7/R8 forwarded count"},
              fwd_cnt, exp_acc ? npay : 0);
        check(fwd_bad == 0, {req, " R7 payload order"}, fwd_bad, 0);
        check(last_cnt == ((exp_acc && npay > 0) ? 1 : 0), {req, " R7 last marker"},
              last_cnt, (exp_acc && npay > 0) ? 1 : 0);
        pw_uc = 1'b0; pw_mc = 1'b0;
    endtask

    task automatic t_reset();
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(dec_valid == 1'b0, "R1 dec_valid after reset", dec_valid, 0);
        send_frame(48'h0, 2, -1, -1, 1'b1, "R1 zero station");
        send_frame(MCA, 2, -1, -1, 1'b0, "R1 empty table");
    endtask

    task automatic t_unicast();
        write_uc(STA);
        idle(2);
        send_frame(STA, 4, -1, -1, 1'b1, "R2 station");
        send_frame(48'h5544_3322_1102, 3, -1, -1, 1'b0, "R6 byte order");
        send_frame(STA, 0, -1, -1, 1'b1, "R7 header only");
    endtask

    task automatic t_bcast();
        send_frame(BCAST, 3, -1, -1, 1'b1, "R3 broadcast");
        send_frame(48'hFFFF_FFFF_FFFE, 3, -1, -1, 1'b0, "R5 near broadcast");
    endtask

    task automatic t_mcast();
        write_mc(3, MCA, 1'b1);
        write_mc(ENT - 1, MCB, 1'b1);
        write_mc(5, 48'h0100_5E7F_0001, 1'b0);
        idle(2);
        send_frame(MCA, 2, -1, -1, 1'b1, "R4 entry 3");
        send_frame(MCB, 2, -1, -1, 1'b1, "R4 last entry");
        send_frame(48'h0100_5E7F_0001, 2, -1, -1, 1'b0, "R4 invalid entry");
        write_mc(3, MCA, 1'b0);
        idle(2);
        send_frame(MCA, 2, -1, -1, 1'b0, "R4 cleared entry");
    endtask

    task automatic t_drop();
        send_frame(48'h0A0B_0C0D_0E0F, 5, -1, -1, 1'b0, "R5 R8 no match");
        send_frame(STA, 3, -1, -1, 1'b1, "R8 next frame");
    endtask

    task automatic t_write_during();
        pw_mc = 1'b1; pw_idx = 3'd0; pw_addr = MCA; pw_vld = 1'b1;
        send_frame(MCA, 2, -1, 2, 1'b0, "R9 table write mid frame");
        send_frame(MCA, 2, -1, -1, 1'b1, "R9 table write next frame");
        pw_mc = 1'b1; pw_idx = 3'd1; pw_addr = 48'h0100_5E11_2233; pw_vld = 1'b1;
        send_frame(48'h0100_5E11_2233, 2, -1, 0, 1'b0, "R9 write on first byte");
        send_frame(48'h0100_5E11_2233, 2, -1, -1, 1'b1, "R9 first byte next frame");
        pw_uc = 1'b1; pw_addr = 48'h0266_7788_99AA;
        send_frame(48'h0266_7788_99AA, 2, -1, 4, 1'b0, "R9 station write mid frame");
        send_frame(48'h0266_7788_99AA, 2, -1, -1, 1'b1, "R9 station next frame");
        send_frame(STA, 2, -1, -1, 1'b0, "R9 old station gone");
    endtask

    task automatic t_short();
        clr_mon();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = BCAST[47 - 8*i -: 8]; in_last = (i == 2);
        end
        idle(4);
        check(dec_cnt == 0, "R10 short frame no decision", dec_cnt, 0);
        check(fwd_cnt == 0, "R10 short frame no output", fwd_cnt, 0);
        send_frame(48'h0266_7788_99AA, 3, -1, -1, 1'b1, "R10 frame after short");
    endtask

    task automatic t_gaps();
        send_frame(48'h0266_7788_99AA, 5, 2, -1, 1'b1, "R11 gap in address");
        send_frame(48'h0266_7788_99AA, 5, 8, -1, 1'b1, "R11 gap in payload");
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        #1;
        t_reset();
        t_unicast();
        t_bcast();
        t_mcast();
        t_drop();
        t_write_during();
        t_short();
        t_gaps();
        finish_run();
    end
endmodule